// File: doc/BRIEF.md
# Addressed Serial Configuration Port

This block is the write-only configuration slave of a two-channel voice transcoder. A host drives a three-wire bus: a serial clock, a data line and an active-low select. Up to 64 transcoders share these wires, and each one is told apart by a 6-bit address strapped on its pins. The host opens a transfer with an address/command byte. That byte names the target device and picks the X or Y channel. The next byte sets that channel's control register. An optional third and fourth byte set the channel's input and output time-slot numbers. A device whose strap does not match the address ignores the rest of the transfer.

The serial clock, data and select inputs are taken as already synchronous to the block clock `clk`. The block finds rising serial-clock edges by comparing each sample with the one before, so `clk` must run several times faster than the serial clock. A busy output tells the datapath to tri-state its outputs while an update is under way. The compression engine sends a per-channel pulse when it has finished an algorithm reset, and that pulse clears the request bit. When the hardware-mode strap is driven low, the serial port is switched off and both time-slot numbers read as zero.

Top module: `cfg_serial_port`

## Requirements
- R1: While `cs_n` is low and `hw_mode_n` is high, `sdi` is sampled at each rising edge of `sclk`. Bits arrive least significant first, and every eight bits form one byte.
- R2: In the first byte of a transfer, bits 5..0 are compared with `dev_addr`. Bit 6 selects the channel (1 = X, 0 = Y). Bit 7 is not examined.
- R3: When the first byte does not match `dev_addr`, no register of either channel changes during that transfer, and `busy` stays low.
- R4: After a match, the second byte is written whole into the selected channel's control register as soon as its eighth bit arrives. The other channel's register is left unchanged. The field layout is: bit 0 compress=1/expand=0, bit 1 algorithm select 2, bit 2 mu-law=1/A-law=0, bit 3 bypass, bit 4 algorithm reset, bit 5 idle, bit 6 algorithm select 1, bit 7 algorithm select 0.
- R5: After a match, bits 5..0 of the third byte become the channel's input slot number, and bits 5..0 of the fourth byte become its output slot number. Each is written only once its byte is complete. Bits 7..6 are dropped, and any byte after the fourth is ignored.
- R6: Raising `cs_n` part-way through a byte throws away the partial bits. The next transfer starts again with an address byte.
- R7: After reset, both control registers read 0x20 (only the idle bit set), all four slot numbers read 0, and `busy` is low.
- R8: A one-cycle pulse on `alg_rst_done[c]` (bit 1 = X, bit 0 = Y) clears bit 4 of channel c's control register. All other bits and the other channel are left unchanged.
- R9: `busy` rises in the cycle after a matching address byte completes. It stays high until the first clock edge at which `cs_n` is seen high.
- R10: While `hw_mode_n` is low, serial traffic is ignored, `busy` is low and all slot outputs read 0. When `hw_mode_n` returns high, the stored slot numbers show again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than sclk |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_mode_n | input | 1 | Low selects hardware mode and disables the port |
| dev_addr | input | 6 | Strapped device address |
| sclk | input | 1 | Serial clock, synchronous to clk |
| sdi | input | 1 | Serial data, LSB first |
| cs_n | input | 1 | Active-low select |
| alg_rst_done | input | 2 | Engine pulse: algorithm reset finished (1 = X, 0 = Y) |
| ctrl_x | output | 8 | X channel control register |
| ctrl_y | output | 8 | Y channel control register |
| in_slot_x | output | 6 | X input time slot |
| out_slot_x | output | 6 | X output time slot |
| in_slot_y | output | 6 | Y input time slot |
| out_slot_y | output | 6 | Y output time slot |
| busy | output | 1 | Update in progress; tri-state request |

## Verification
A slipped bit counter rotates or misaligns a register value, and that error shows on the register outputs within a clock of the byte that should have completed. A wrong byte index or a stale match flag writes the wrong field or the wrong channel. It can also let a foreign transfer change a register, which the bench finds when it compares all six register outputs after every transfer. A match flag that does not clear leaves `busy` high past the clock after the select rises, so the fault shows within one cycle.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int BYTE_W   = 8;
  localparam int SLOT_W   = 6;
  localparam int ADDR_W   = 6;
  localparam int NCH      = 2;
  localparam int CH_Y     = 0;
  localparam int CH_X     = 1;
  localparam int ALRST_BIT = 4;
  localparam logic [BYTE_W-1:0] CTRL_RST = 8'h20;

  localparam logic [2:0] IDX_ADDR  = 3'd0;
  localparam logic [2:0] IDX_CTRL  = 3'd1;
  localparam logic [2:0] IDX_ISLOT = 3'd2;
  localparam logic [2:0] IDX_OSLOT = 3'd3;
  localparam logic [2:0] IDX_DONE  = 3'd4;
endpackage

// File: rtl/cfgp_shifter.sv
module cfgp_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              cs_n,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_data
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic              sclk_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-2:0] sh_q, sh_n;
  logic              active, rise;

  assign active    = enable & ~cs_n;
  assign rise      = sclk & ~sclk_q;
  assign byte_stb  = active & rise & (cnt_q == LAST);
  assign byte_data = {sdi, sh_q};

  always_comb begin
    cnt_n = cnt_q;
    sh_n  = sh_q;
    if (!active) begin
      cnt_n = '0;
    end else if (rise) begin
      sh_n  = {sdi, sh_q[BYTE_W-2:1]};
      cnt_n = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else begin
      sclk_q <= sclk;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
    end
  end

  // partial bytes are discarded when the select rises
  assert_cnt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cnt_q == '0));
endmodule

// File: rtl/cfgp_gate.sv
module cfgp_gate #(
  parameter int ADDR_W = 6,
  parameter int NCH    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cs_n,
  input  logic              byte_stb,
  input  logic [ADDR_W:0]   byte_lo,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic              busy,
  output logic [NCH-1:0]    wr_ctrl,
  output logic [NCH-1:0]    wr_islot,
  output logic [NCH-1:0]    wr_oslot
);
  import cfgp_pkg::*;
  localparam int CH_BIT = ADDR_W;

  logic [2:0]     idx_q, idx_n;
  logic           match_q, match_n;
  logic           chan_q, chan_n;
  logic           hit;
  logic [NCH-1:0] sel;

  always_comb begin
    idx_n   = idx_q;
    match_n = match_q;
    chan_n  = chan_q;
    if (!enable || cs_n) begin
      idx_n   = IDX_ADDR;
      match_n = 1'b0;
      chan_n  = 1'b0;
    end else if (byte_stb) begin
      if (idx_q == IDX_ADDR) begin
        match_n = (byte_lo[ADDR_W-1:0] == dev_addr);
        chan_n  = byte_lo[CH_BIT];
      end
      if (idx_q != IDX_DONE) idx_n = idx_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= IDX_ADDR;
      match_q <= 1'b0;
      chan_q  <= 1'b0;
    end else begin
      idx_q   <= idx_n;
      match_q <= match_n;
      chan_q  <= chan_n;
    end
  end

  assign hit      = byte_stb & match_q;
  assign sel      = NCH'(1) << chan_q;
  assign wr_ctrl  = (hit && idx_q == IDX_CTRL)  ? sel : '0;
  assign wr_islot = (hit && idx_q == IDX_ISLOT) ? sel : '0;
  assign wr_oslot = (hit && idx_q == IDX_OSLOT) ? sel : '0;
  assign busy     = match_q;

  assert_busy_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !busy);
  assert_busy_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(byte_stb));
  assert_one_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_ctrl, wr_islot, wr_oslot}));
endmodule

// File: rtl/cfgp_chan.sv
module cfgp_chan #(
  parameter int BYTE_W = 8,
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_en,
  input  logic              wr_ctrl,
  input  logic              wr_islot,
  input  logic              wr_oslot,
  input  logic              alg_done,
  input  logic [BYTE_W-1:0] data,
  output logic [BYTE_W-1:0] ctrl,
  output logic [SLOT_W-1:0] islot,
  output logic [SLOT_W-1:0] oslot
);
  import cfgp_pkg::*;

  logic [BYTE_W-1:0] ctrl_q, ctrl_n;
  logic [SLOT_W-1:0] is_q, is_n, os_q, os_n;

  always_comb begin
    ctrl_n = ctrl_q;
    is_n   = is_q;
    os_n   = os_q;
    if (wr_ctrl)       ctrl_n = data;
    else if (alg_done) ctrl_n[ALRST_BIT] = 1'b0;
    if (wr_islot)      is_n = data[SLOT_W-1:0];
    if (wr_oslot)      os_n = data[SLOT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      is_q   <= '0;
      os_q   <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      is_q   <= is_n;
      os_q   <= os_n;
    end
  end

  assign ctrl  = ctrl_q;
  assign islot = slot_en ? is_q : '0;
  assign oslot = slot_en ? os_q : '0;

  assert_alrst_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alg_done && !wr_ctrl) |=> !ctrl_q[ALRST_BIT]);
  assert_hw_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_en && !alg_done) |=> ($stable(ctrl_q) && $stable(is_q) && $stable(os_q)));
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_mode_n,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              cs_n,
  input  logic [NCH-1:0]    alg_rst_done,
  output logic [BYTE_W-1:0] ctrl_x,
  output logic [BYTE_W-1:0] ctrl_y,
  output logic [SLOT_W-1:0] in_slot_x,
  output logic [SLOT_W-1:0] out_slot_x,
  output logic [SLOT_W-1:0] in_slot_y,
  output logic [SLOT_W-1:0] out_slot_y,
  output logic              busy
);
  logic              byte_stb;
  logic [BYTE_W-1:0] byte_data;
  logic [NCH-1:0]    wr_ctrl, wr_islot, wr_oslot;
  logic [BYTE_W-1:0] ctrl_a  [NCH];
  logic [SLOT_W-1:0] islot_a [NCH];
  logic [SLOT_W-1:0] oslot_a [NCH];

  cfgp_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .enable(hw_mode_n), .sclk(sclk), .sdi(sdi),
    .cs_n(cs_n), .byte_stb(byte_stb), .byte_data(byte_data)
  );

  cfgp_gate #(.ADDR_W(ADDR_W), .NCH(NCH)) u_gate (
    .clk(clk), .rst_n(rst_n), .enable(hw_mode_n), .cs_n(cs_n),
    .byte_stb(byte_stb), .byte_lo(byte_data[ADDR_W:0]), .dev_addr(dev_addr),
    .busy(busy), .wr_ctrl(wr_ctrl), .wr_islot(wr_islot), .wr_oslot(wr_oslot)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cfgp_chan #(.BYTE_W(BYTE_W), .SLOT_W(SLOT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .slot_en(hw_mode_n),
      .wr_ctrl(wr_ctrl[c]), .wr_islot(wr_islot[c]), .wr_oslot(wr_oslot[c]),
      .alg_done(alg_rst_done[c]), .data(byte_data),
      .ctrl(ctrl_a[c]), .islot(islot_a[c]), .oslot(oslot_a[c])
    );
  end

  assign ctrl_x     = ctrl_a[CH_X];
  assign ctrl_y     = ctrl_a[CH_Y];
  assign in_slot_x  = islot_a[CH_X];
  assign out_slot_x = oslot_a[CH_X];
  assign in_slot_y  = islot_a[CH_Y];
  assign out_slot_y = oslot_a[CH_Y];
endmodule

// File: tb/cfg_serial_port_bench.sv
module cfg_serial_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] DEV = 6'h2B;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_mode_n = 1'b1;
  logic       sclk = 1'b1;
  logic       sdi = 1'b0;
  logic       cs_n = 1'b1;
  logic [1:0] alg_rst_done = 2'b00;
  logic [7:0] ctrl_x, ctrl_y;
  logic [5:0] in_slot_x, out_slot_x, in_slot_y, out_slot_y;
  logic       busy;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // bench model, index 1 = X, 0 = Y
  logic [7:0] m_ctrl [2];
  logic [5:0] m_is [2];
  logic [5:0] m_os [2];
  logic [7:0] xb [5];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_port u_cfg_serial_port (
    .clk(clk), .rst_n(rst_n), .hw_mode_n(hw_mode_n), .dev_addr(DEV),
    .sclk(sclk), .sdi(sdi), .cs_n(cs_n), .alg_rst_done(alg_rst_done),
    .ctrl_x(ctrl_x), .ctrl_y(ctrl_y), .in_slot_x(in_slot_x),
    .out_slot_x(out_slot_x), .in_slot_y(in_slot_y), .out_slot_y(out_slot_y),
    .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_slot(input logic [5:0] v);
    return hw_mode_n ? v : 6'd0;
  endfunction

  task automatic chk_regs(input string tag);
    chk({tag, " ctrl_x"}, ctrl_x, m_ctrl[1]);
    chk({tag, " ctrl_y"}, ctrl_y, m_ctrl[0]);
    chk({tag, " in_slot_x"}, in_slot_x, exp_slot(m_is[1]));
    chk({tag, " out_slot_x"}, out_slot_x, exp_slot(m_os[1]));
    chk({tag, " in_slot_y"}, in_slot_y, exp_slot(m_is[0]));
    chk({tag, " out_slot_y"}, out_slot_y, exp_slot(m_os[0]));
  endtask

  task automatic send_bit(input logic b);
    sdi  = b;
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic open_xfer();
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic close_xfer();
    cs_n = 1'b1;
    sclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // model update for a transfer of n whole bytes in xb
  function automatic void model_apply(input int n);
    int ch;
    if (!hw_mode_n || n < 1) return;
    if (xb[0][5:0] != DEV) return;
    ch = xb[0][6] ? 1 : 0;
    if (n >= 2) m_ctrl[ch] = xb[1];
    if (n >= 3) m_is[ch] = xb[2][5:0];
    if (n >= 4) m_os[ch] = xb[3][5:0];
  endfunction

  task automatic run_xfer(input int n, input int extra, input string tag);
    bit matched;
    matched = hw_mode_n && (xb[0][5:0] == DEV);
    open_xfer();
    for (int i = 0; i < n; i++) begin
      send_byte(xb[i]);
      if (i == 0) chk({tag, " R9 busy after address"}, busy, matched);
    end
    for (int i = 0; i < extra; i++) send_bit(1'($urandom));
    close_xfer();
    chk({tag, " R9 busy after close"}, busy, 1'b0);
    model_apply(n);
    chk_regs(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < 2; c++) begin
      m_ctrl[c] = 8'h20; m_is[c] = '0; m_os[c] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7 reset state
    chk_regs("R7 reset");
    chk("R7 busy reset", busy, 1'b0);

    // R2 R4 R5 full write to X, LSB-first ordering (R1)
    xb[0] = {2'b01, DEV}; xb[1] = 8'h96; xb[2] = 8'hC5; xb[3] = 8'h3A;
    run_xfer(4, 0, "R1 R4 R5 full X");
    // R2 bit 7 ignored, Y channel, two bytes only
    xb[0] = {2'b10, DEV}; xb[1] = 8'h5D;
    run_xfer(2, 0, "R2 R4 two-byte Y");
    // R3 mismatch
    xb[0] = {2'b01, DEV ^ 6'h10}; xb[1] = 8'hFF; xb[2] = 8'h11; xb[3] = 8'h22;
    run_xfer(4, 0, "R3 mismatch");
    // R5 fifth byte ignored, third byte complete but fourth partial
    xb[0] = {2'b00, DEV}; xb[1] = 8'h01; xb[2] = 8'h3F; xb[3] = 8'h2A; xb[4] = 8'h15;
    run_xfer(5, 0, "R5 fifth byte Y");
    xb[0] = {2'b01, DEV}; xb[1] = 8'h10; xb[2] = 8'hE7; xb[3] = 8'h0C;
    run_xfer(3, 5, "R5 R6 partial fourth X");
    // R6 aborted address byte then fresh transfer
    xb[0] = {2'b01, DEV};
    run_xfer(0, 5, "R6 partial address");
    xb[0] = {2'b01, DEV}; xb[1] = 8'h7E;
    run_xfer(2, 0, "R6 fresh after abort");

    // R8 algorithm-reset completion on X (bit 4 currently set by 0x7E? 0x7E has bit4=1)
    @(negedge clk); alg_rst_done = 2'b10;
    @(negedge clk); alg_rst_done = 2'b00;
    m_ctrl[1][4] = 1'b0;
    @(negedge clk);
    chk_regs("R8 clear X");
    xb[0] = {2'b00, DEV}; xb[1] = 8'h1F;
    run_xfer(2, 0, "R8 setup Y");
    @(negedge clk); alg_rst_done = 2'b01;
    @(negedge clk); alg_rst_done = 2'b00;
    m_ctrl[0][4] = 1'b0;
    @(negedge clk);
    chk_regs("R8 clear Y");

    // R10 hardware mode
    hw_mode_n = 1'b0;
    repeat (2) @(negedge clk);
    chk_regs("R10 hw slots zero");
    xb[0] = {2'b01, DEV}; xb[1] = 8'hAA; xb[2] = 8'h21; xb[3] = 8'h12;
    run_xfer(4, 0, "R10 hw ignored");
    hw_mode_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_regs("R10 hw released");

    // random traffic
    for (int t = 0; t < 150; t++) begin
      int n, extra;
      logic [5:0] a;
      n = 1 + int'($urandom % 5);
      extra = int'($urandom % 8);
      a = ($urandom % 2) ? DEV : 6'($urandom);
      if (a == DEV && ($urandom % 4 == 0)) a = DEV ^ 6'h01;
      xb[0] = {1'($urandom), 1'($urandom), a};
      for (int k = 1; k < 5; k++) xb[k] = 8'($urandom);
      run_xfer(n, extra, "R1 R2 R3 R4 R5 R6 random");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule